// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Sequencer

This block lets synchronous logic read and write an external 2048 x 8 asynchronous static RAM. The RAM has a shared tri-state data bus and three active-low strobes: chip select, output enable and write enable. On the user side there is a single request/acknowledge port that carries an 11-bit word address, a write flag, write data and returned read data. The block turns each request into a strobe sequence on the memory pins and controls the direction of the data bus.

The clock period in nanoseconds is a parameter. From it the block works out how many clock cycles each phase of a strobe sequence needs. The minimum timing the memory needs is:

- 20 ns of address setup before the write strobe.
- A 25 ns write pulse.
- 50 ns from a valid address to the end of a write.
- 20 ns of data setup and 5 ns of data hold and recovery around the end of a write.
- 70 ns for each read or write cycle.
- 40 ns of access time after output enable falls.
- Up to 30 ns for the memory to release the bus after its output is turned off.

Each count is the required time divided by the period, rounded up. With the default 4 ns clock the counts are: setup 5, pulse 8, write tail 5, read access 18 and bus turnaround 8.

When no request is in progress the block leaves chip select high, so the memory stays in standby. When a write comes directly after a read, the block waits out the bus-release time before it turns on its own data drivers.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is low, and up to the first request after reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `ack` is low and the block does not drive `mem_dq`.
- R2: `mem_cs_n` is high in every cycle in which no access is in progress. An access lasts from the accepting clock edge until the cycle in which `ack` is high.
- R3: In a write, `mem_cs_n` goes low for setup+pulse cycles (13 at 4 ns). `mem_we_n` is low only for the final pulse cycles of that window (8 at 4 ns). `mem_oe_n` stays high for the whole write, and `mem_we_n` is never low while `mem_cs_n` is high.
- R4: During a write the block drives the request's data onto `mem_dq` from the start of setup to the end of the write tail. `mem_addr` does not change while `mem_cs_n` is low.
- R5: `ack` for a write is high in the cycle that starts setup+pulse+tail clock edges after the accepting edge (18 at 4 ns). This makes the write cycle at least 70 ns long.
- R6: In a read, `mem_cs_n` and `mem_oe_n` are low together for the access count (18 at 4 ns) and `mem_we_n` stays high. The data on `mem_dq` at the clock edge that ends the last access cycle appears on `rdata` in the same cycle as `ack`. `rdata` keeps that value until the next read completes.
- R7: The block never drives `mem_dq` while `mem_oe_n` is low.
- R8: When a write is the first access after a read, at least the turnaround count of cycles (8 at 4 ns) pass with `mem_oe_n` high before the block drives `mem_dq`. That write's `ack` arrives that many cycles later than R5 gives.
- R9: `req` (together with `wr`, `addr` and `wdata`) is accepted only at a clock edge where the block is idle and `ack` is low. `ack` is high for exactly one cycle, once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its period in ns is CLK_PERIOD_NS |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request; keep high with the fields stable until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address of the request |
| wdata | input | DATA_W | Data to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data from the last read |
| mem_addr | output | ADDR_W | Address pins of the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq | inout | DATA_W | Shared tri-state data bus |

## Verification
The assertions check the following on every cycle:
- The write strobe never falls outside chip select or together with output enable.
- The address is steady while the chip is selected.
- The block's drivers are never on while output enable is low.
- Each write pulse and each read access has exactly its computed length.
- The block waits the turnaround count after output enable rises before it drives the bus.
- `ack` never lasts longer than one cycle.

Only the bench scenarios can show the following, because they need a memory model and a record of expected contents:
- Data written to the memory comes back at the same address, including the first and last addresses and alternating bit patterns.
- Reset leaves the bus released.
- The write latency is exact both with and without the extra turnaround.
- `rdata` holds its value across a later write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   // Minimum timing of the attached memory, in nanoseconds
   localparam int unsigned T_ADDR_SETUP_NS  = 20;
   localparam int unsigned T_WE_PULSE_NS    = 25;
   localparam int unsigned T_ADDR_TO_END_NS = 50;
   localparam int unsigned T_DATA_SETUP_NS  = 20;
   localparam int unsigned T_RECOVER_NS     = 5;
   localparam int unsigned T_CYCLE_NS       = 70;
   localparam int unsigned T_OE_ACCESS_NS   = 40;
   localparam int unsigned T_BUS_RELEASE_NS = 30;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_TURN   = 3'd1,
      ST_WSETUP = 3'd2,
      ST_WPULSE = 3'd3,
      ST_WTAIL  = 3'd4,
      ST_RACC   = 3'd5
   } seq_state_e;

   function automatic int unsigned ceil_cyc(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned sat_sub(input int unsigned a, input int unsigned b);
      return (a > b) ? (a - b) : 0;
   endfunction

   function automatic int unsigned cyc_setup(input int unsigned per);
      return max_u(1, ceil_cyc(T_ADDR_SETUP_NS, per));
   endfunction

   function automatic int unsigned cyc_pulse(input int unsigned per);
      int unsigned s;
      s = cyc_setup(per);
      return max_u(max_u(1, ceil_cyc(T_WE_PULSE_NS, per)),
                   max_u(sat_sub(ceil_cyc(T_ADDR_TO_END_NS, per), s),
                         sat_sub(ceil_cyc(T_DATA_SETUP_NS, per), s)));
   endfunction

   function automatic int unsigned cyc_tail(input int unsigned per);
      return max_u(max_u(1, ceil_cyc(T_RECOVER_NS, per)),
                   sat_sub(ceil_cyc(T_CYCLE_NS, per), cyc_setup(per) + cyc_pulse(per)));
   endfunction

   function automatic int unsigned cyc_read(input int unsigned per);
      return max_u(1, max_u(ceil_cyc(T_CYCLE_NS, per), ceil_cyc(T_OE_ACCESS_NS, per)));
   endfunction

   function automatic int unsigned cyc_turn(input int unsigned per);
      return ceil_cyc(T_BUS_RELEASE_NS, per);
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cap_en,
   output logic [DATA_W-1:0] rdata,
   inout  wire  [DATA_W-1:0] dq
);

   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_bit
         assign dq[b] = drv_en ? wdata[b] : 1'bz;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (cap_en)
         rdata <= dq;
   end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 11,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 4,
   parameter int unsigned CNT_W         = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tmr_expired,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              ack,
   output logic              cap_en,
   output logic              drv_en,
   output logic [DATA_W-1:0] drv_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n
);

   localparam int unsigned N_SET = cyc_setup(CLK_PERIOD_NS);
   localparam int unsigned N_WP  = cyc_pulse(CLK_PERIOD_NS);
   localparam int unsigned N_WT  = cyc_tail(CLK_PERIOD_NS);
   localparam int unsigned N_RD  = cyc_read(CLK_PERIOD_NS);
   localparam int unsigned N_TRN = cyc_turn(CLK_PERIOD_NS);

   seq_state_e state_q, state_d;
   logic       accept, finish, bus_dirty;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      finish   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req && !ack) begin
               accept   = 1'b1;
               tmr_load = 1'b1;
               if (!wr) begin
                  state_d = ST_RACC;
                  tmr_val = CNT_W'(N_RD - 1);
               end else if (bus_dirty) begin
                  state_d = ST_TURN;
                  tmr_val = CNT_W'(N_TRN - 1);
               end else begin
                  state_d = ST_WSETUP;
                  tmr_val = CNT_W'(N_SET - 1);
               end
            end
         end
         ST_TURN: begin
            if (tmr_expired) begin
               state_d  = ST_WSETUP;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(N_SET - 1);
            end
         end
         ST_WSETUP: begin
            if (tmr_expired) begin
               state_d  = ST_WPULSE;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(N_WP - 1);
            end
         end
         ST_WPULSE: begin
            if (tmr_expired) begin
               state_d  = ST_WTAIL;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(N_WT - 1);
            end
         end
         ST_WTAIL: begin
            if (tmr_expired) begin
               state_d = ST_IDLE;
               finish  = 1'b1;
            end
         end
         ST_RACC: begin
            if (tmr_expired) begin
               state_d = ST_IDLE;
               finish  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign cap_en = (state_q == ST_RACC) && tmr_expired;

   // Turnaround tracking exists only when the bus-release time is non-zero
   generate
      if (N_TRN > 0) begin : g_turn
         logic dirty_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dirty_q <= 1'b0;
            else if (cap_en)
               dirty_q <= 1'b1;
            else if (state_d == ST_WSETUP)
               dirty_q <= 1'b0;
         end
         assign bus_dirty = dirty_q;
      end else begin : g_no_turn
         assign bus_dirty = 1'b0;
      end
   endgenerate

   // Strobes are registered from the next state so the pins never glitch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mem_cs_n <= 1'b1;
         mem_oe_n <= 1'b1;
         mem_we_n <= 1'b1;
         drv_en   <= 1'b0;
         ack      <= 1'b0;
         mem_addr <= '0;
         drv_data <= '0;
      end else begin
         state_q  <= state_d;
         mem_cs_n <= !(state_d inside {ST_WSETUP, ST_WPULSE, ST_RACC});
         mem_oe_n <= (state_d != ST_RACC);
         mem_we_n <= (state_d != ST_WPULSE);
         drv_en   <= (state_d inside {ST_WSETUP, ST_WPULSE, ST_WTAIL});
         ack      <= finish;
         if (accept) begin
            mem_addr <= addr;
            drv_data <= wdata;
         end
      end
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 11,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CLK_PERIOD_NS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   inout  wire  [DATA_W-1:0] mem_dq
);

   localparam int unsigned N_MAX = max_u(max_u(cyc_setup(CLK_PERIOD_NS), cyc_pulse(CLK_PERIOD_NS)),
                                         max_u(max_u(cyc_tail(CLK_PERIOD_NS), cyc_read(CLK_PERIOD_NS)),
                                               cyc_turn(CLK_PERIOD_NS)));
   localparam int unsigned CNT_W = max_u(1, $clog2(N_MAX + 1));

   generate
      if (CLK_PERIOD_NS < 1) begin : g_bad_period
         $error("CLK_PERIOD_NS must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be at least 1");
      end
   endgenerate

   logic              tmr_load, tmr_expired, cap_en, drv_en;
   logic [CNT_W-1:0]  tmr_val;
   logic [DATA_W-1:0] drv_data;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sram_seq_fsm #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .CLK_PERIOD_NS (CLK_PERIOD_NS),
      .CNT_W         (CNT_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (req),
      .wr          (wr),
      .addr        (addr),
      .wdata       (wdata),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .ack         (ack),
      .cap_en      (cap_en),
      .drv_en      (drv_en),
      .drv_data    (drv_data),
      .mem_addr    (mem_addr),
      .mem_cs_n    (mem_cs_n),
      .mem_oe_n    (mem_oe_n),
      .mem_we_n    (mem_we_n)
   );

   sram_dq_port #(.DATA_W(DATA_W)) u_dq (
      .clk    (clk),
      .rst_n  (rst_n),
      .drv_en (drv_en),
      .wdata  (drv_data),
      .cap_en (cap_en),
      .rdata  (rdata),
      .dq     (mem_dq)
   );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W        = 11,
   parameter int unsigned CLK_PERIOD_NS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              drv_en,
   input logic [ADDR_W-1:0] mem_addr
);

   localparam int unsigned N_WP  = cyc_pulse(CLK_PERIOD_NS);
   localparam int unsigned N_RD  = cyc_read(CLK_PERIOD_NS);
   localparam int unsigned N_TRN = cyc_turn(CLK_PERIOD_NS);

   int unsigned we_run, oe_run, oe_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run  <= 0;
         oe_run  <= 0;
         oe_idle <= N_TRN;
      end else begin
         we_run  <= mem_we_n ? 0 : we_run + 1;
         oe_run  <= mem_oe_n ? 0 : oe_run + 1;
         if (!mem_oe_n)
            oe_idle <= 0;
         else if (oe_idle < N_TRN)
            oe_idle <= oe_idle + 1;
      end
   end

   AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_cs_n);  // R3
   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);  // R3
   AST_WE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == N_WP));  // R3
   AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));  // R4
   AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> drv_en);  // R4
   AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_run == N_RD));  // R6
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> mem_oe_n);  // R7
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> (oe_idle >= N_TRN));  // R8
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);  // R9

endmodule

bind sram_async_ctrl sram_ctrl_checker #(
   .ADDR_W        (ADDR_W),
   .CLK_PERIOD_NS (CLK_PERIOD_NS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (ack),
   .mem_cs_n (mem_cs_n),
   .mem_oe_n (mem_oe_n),
   .mem_we_n (mem_we_n),
   .drv_en   (drv_en),
   .mem_addr (mem_addr)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

   localparam int PER = 4;
   localparam int AW  = 11;
   localparam int DW  = 8;

   function automatic int up(input int ns);
      return (ns + PER - 1) / PER;
   endfunction

   localparam int E_SET = up(20);
   localparam int E_WP  = (up(25) > up(50) - E_SET) ? up(25) : up(50) - E_SET;
   localparam int E_WT  = (up(5) > up(70) - E_SET - E_WP) ? up(5) : up(70) - E_SET - E_WP;
   localparam int E_RD  = (up(70) > up(40)) ? up(70) : up(40);
   localparam int E_TRN = up(30);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic ack;
   logic [DW-1:0] rdata;
   logic [AW-1:0] mem_addr;
   logic cs_n, oe_n, we_n;
   wire  [DW-1:0] dq;

   always #(PER / 2.0) clk = ~clk;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
      .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_cs_n(cs_n),
      .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_dq(dq)
   );

   // Memory model
   logic [DW-1:0] ram [0:(1<<AW)-1];
   logic [DW-1:0] shadow [0:(1<<AW)-1];
   logic wr_live = 1'b0;
   assign dq = (!cs_n && !oe_n && we_n) ? ram[mem_addr] : {DW{1'bz}};
   always @(negedge clk) wr_live <= (!cs_n && !we_n);
   always @(posedge we_n) if (wr_live) ram[mem_addr] = dq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   typedef struct packed {
      logic          is_rd;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
   } exp_t;
   exp_t sb_q[$];

   // Monitor state
   int we_cnt = 0, cs_cnt = 0, oe_cnt = 0;
   int last_we = 0, last_cs = 0, last_oe = 0;
   int oe_hi = 1000, last_gap = 1000;
   bit prev_z = 1;
   int contention = 0, ack_long = 0, bus_err = 0, addr_err = 0, oe_in_wr = 0;
   bit ack_prev = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (ack) begin
            if (sb_q.size() == 0) begin
               chk(0, "R9 ack without request", 1, 0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               if (e.is_rd) chk(rdata === e.d, "R6 read data", int'(rdata), int'(e.d));
            end
         end
         if (ack && ack_prev) ack_long++;
         ack_prev = ack;
         if (!we_n) we_cnt++; else if (we_cnt > 0) begin last_we = we_cnt; we_cnt = 0; end
         if (!cs_n) cs_cnt++; else if (cs_cnt > 0) begin last_cs = cs_cnt; cs_cnt = 0; end
         if (!oe_n) oe_cnt++; else if (oe_cnt > 0) begin last_oe = oe_cnt; oe_cnt = 0; end
         if (!oe_n) oe_hi = 0;
         else begin
            if (dq !== {DW{1'bz}} && prev_z) last_gap = oe_hi;
            oe_hi++;
         end
         prev_z = (dq === {DW{1'bz}});
         if (dq !== {DW{1'bz}} && $isunknown(dq)) contention++;
         if (!we_n && dq !== wdata) bus_err++;
         if (!cs_n && mem_addr !== addr) addr_err++;
         if (!we_n && !oe_n) oe_in_wr++;
      end
   end

   task automatic run_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int exp_lat);
      exp_t e;
      int lat;
      e.is_rd = !w;
      e.a = a;
      e.d = w ? d : shadow[a];
      if (w) shadow[a] = d;
      sb_q.push_back(e);
      @(negedge clk);
      req = 1'b1; wr = w; addr = a; wdata = d;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!ack && lat < 200);
      req = 1'b0;
      if (w) chk(lat == exp_lat, "R5 write ack latency", lat, exp_lat);
      else   chk(lat == exp_lat, "R6 read ack latency", lat, exp_lat);
      @(negedge clk);
      chk(cs_n === 1'b1, "R2 standby when idle", int'(cs_n), 1);
      if (w) begin
         chk(last_we == E_WP, "R3 write pulse cycles", last_we, E_WP);
         chk(last_cs == E_SET + E_WP, "R3 select cycles in write", last_cs, E_SET + E_WP);
      end else begin
         chk(last_oe == E_RD, "R6 output enable cycles", last_oe, E_RD);
         chk(last_cs == E_RD, "R6 select cycles in read", last_cs, E_RD);
      end
   endtask

   localparam int LAT_W = E_SET + E_WP + E_WT + 1;
   localparam int LAT_R = E_RD + 1;

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) begin
         ram[i] = '0;
         shadow[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(cs_n === 1'b1 && oe_n === 1'b1 && we_n === 1'b1, "R1 strobes high in reset",
          int'({cs_n, oe_n, we_n}), 7);
      chk(ack === 1'b0, "R1 ack low in reset", int'(ack), 0);
      chk(dq === {DW{1'bz}}, "R1 bus released in reset", int'(dq === {DW{1'bz}}), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(cs_n === 1'b1 && dq === {DW{1'bz}}, "R1 idle after reset", int'(cs_n), 1);

      run_op(1, 11'h000, 8'h5A, LAT_W);
      run_op(1, 11'h7FF, 8'hA5, LAT_W);
      run_op(1, 11'h155, 8'h00, LAT_W);
      run_op(1, 11'h2AA, 8'hFF, LAT_W);
      run_op(0, 11'h000, 8'h00, LAT_R);
      run_op(0, 11'h7FF, 8'h00, LAT_R);
      // R8: write right after a read waits out bus release
      run_op(1, 11'h123, 8'h3C, LAT_W + E_TRN);
      chk(last_gap >= E_TRN, "R8 turnaround cycles", last_gap, E_TRN);
      run_op(0, 11'h123, 8'h00, LAT_R);
      run_op(1, 11'h124, 8'hC3, LAT_W + E_TRN);
      chk(rdata === 8'h3C, "R6 rdata held across write", int'(rdata), 8'h3C);
      run_op(1, 11'h125, 8'h96, LAT_W);
      run_op(0, 11'h155, 8'h00, LAT_R);
      run_op(0, 11'h2AA, 8'h00, LAT_R);
      run_op(0, 11'h400, 8'h00, LAT_R);
      for (int k = 0; k < 6; k++)
         run_op(1, 11'(11'h600 + k), 8'(8'h11 * (k + 1)), (k == 0) ? LAT_W + E_TRN : LAT_W);
      for (int k = 0; k < 6; k++)
         run_op(0, 11'(11'h600 + k), 8'h00, LAT_R);
      run_op(0, 11'h124, 8'h00, LAT_R);

      chk(contention == 0, "R7 bus contention cycles", contention, 0);
      chk(bus_err == 0, "R4 write data on bus", bus_err, 0);
      chk(addr_err == 0, "R4 address steady while selected", addr_err, 0);
      chk(oe_in_wr == 0, "R3 output enable during write pulse", oe_in_wr, 0);
      chk(ack_long == 0, "R9 ack longer than one cycle", ack_long, 0);
      chk(sb_q.size() == 0, "R9 one ack per request", sb_q.size(), 0);
      done = 1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         finish_run();
      end
   end

endmodule